// File: doc/BRIEF.md
# Lane-wise XOR-rotate vector unit

This block takes one 32-bit instruction word and two packed operand vectors. It checks whether the word encodes the exclusive-OR-then-rotate-right vector operation and, if it does, decodes an element width and a rotate amount from one shared packed immediate. For every element of the two operands, the result is the XOR of the pair of elements, rotated right by that amount. No lane is masked.

The unit is a single registered stage, and every output appears one clock after its inputs. It reports four things: the destination index, which is also the first source because the operation is destructive; the second source index; a match flag; and a reserved-size flag. A write enable qualifies the result, and the result vector reads zero whenever nothing is to be written. The vector width `VLEN` is a parameter and must be a multiple of 64, so that every element size divides it evenly. Reading and writing the register file is left to the surrounding pipeline.

Top module: `xr_unit`

## Requirements
- R1: `match_o` is 1 exactly when instruction bits 31:24 are 8'h04, bit 21 is 1 and bits 15:10 are 6'b001101.
- R2: `dst_idx_o` carries instruction bits 4:0 and `src2_idx_o` carries bits 9:5, whether or not the word matches.
- R3: The size code is {bits 23:22, bits 20:19}. A matching word whose size code is 4'b0000 raises `undef_o`. `undef_o` is never 1 without `match_o`.
- R4: The element width is 8 when the size code is 0001, 16 when it is 001x, 32 when it is 01xx and 64 when it is 1xxx.
- R5: The rotate amount equals twice the element width minus the 7-bit value {size code, bits 18:16}. For a valid word it lies between 1 and the element width, inclusive.
- R6: Element e occupies result bits [e*W +: W], with element 0 at the least significant end. Each element equals ROR(opa element XOR opb element, rotate amount), and every element of the vector is updated.
- R7: A rotate amount equal to the element width returns the XOR value unchanged.
- R8: `wr_en_o` is 1 only for a matching, non-reserved word. When it is 0, `res_o` is all zeros.
- R9: All outputs are registered, with one cycle of latency. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| opa_i | input | VLEN | First source operand vector |
| opb_i | input | VLEN | Second source operand vector |
| res_o | output | VLEN | Lane-wise result, zero unless written |
| dst_idx_o | output | 5 | Destination and first source index |
| src2_idx_o | output | 5 | Second source index |
| match_o | output | 1 | Word encodes the operation |
| undef_o | output | 1 | Matching word with reserved size code |
| wr_en_o | output | 1 | Result is to be written back |

## Verification
Decode rejection and the lane datapath work in the same cycle. The datapath always computes a value, and the decode outcome must either let that value through or force it to zero. The bench provokes this by presenting nonzero operands together with words that differ from a valid encoding in one fixed bit, and with words that carry the reserved size code. It judges each case by requiring `res_o` to be zero and `wr_en_o` to be low, while `dst_idx_o` and `src2_idx_o` still track the fields. A second overlap occurs where the width decode meets the rotator at its extremes: a rotate of exactly the element width, and a rotate of 1, are judged against a bit-index model of the rotation.

// File: rtl/xr_pkg.sv
package xr_pkg;

  localparam logic [7:0] OPC_HI  = 8'h04;
  localparam logic [5:0] OPC_MID = 6'b001101;

  typedef enum logic [1:0] {ESZ_8, ESZ_16, ESZ_32, ESZ_64} esz_e;

  typedef struct packed {
    logic       hit;
    logic       rsvd;
    esz_e       esz;
    logic [6:0] rot;
    logic [4:0] dst;
    logic [4:0] src2;
  } dec_t;

  // Highest set bit of the size code picks the element size.
  function automatic esz_e esz_from_code(input logic [3:0] code);
    if (code[3])      return ESZ_64;
    else if (code[2]) return ESZ_32;
    else if (code[1]) return ESZ_16;
    else              return ESZ_8;
  endfunction

  function automatic logic [7:0] width_of(input esz_e esz);
    return 8'd8 << esz;
  endfunction

  // Rotate amount: twice the width minus the packed size/immediate value.
  function automatic logic [6:0] rot_amount(input esz_e esz, input logic [6:0] imm7);
    logic [7:0] diff;
    diff = (width_of(esz) << 1) - {1'b0, imm7};
    return diff[6:0];
  endfunction

endpackage

// File: rtl/xr_decode.sv
module xr_decode
  import xr_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);

  logic [3:0] size_code;
  logic [2:0] imm3;

  assign size_code = {instr_i[23:22], instr_i[20:19]};
  assign imm3      = instr_i[18:16];

  always_comb begin
    dec_o.hit  = (instr_i[31:24] == OPC_HI) && instr_i[21] &&
                 (instr_i[15:10] == OPC_MID);
    dec_o.rsvd = dec_o.hit && (size_code == 4'b0000);
    dec_o.esz  = esz_from_code(size_code);
    dec_o.rot  = rot_amount(dec_o.esz, {size_code, imm3});
    dec_o.dst  = instr_i[4:0];
    dec_o.src2 = instr_i[9:5];
  end

endmodule

// File: rtl/xr_lane_bank.sv
module xr_lane_bank #(
  parameter int VLEN = 128,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0] opa_i,
  input  logic [VLEN-1:0] opb_i,
  input  logic [6:0]      rot_i,
  output logic [VLEN-1:0] y_o
);

  localparam int LANES = VLEN / EW;
  localparam logic [7:0] EW8 = 8'(EW);

  logic [7:0] left_amt;
  assign left_amt = EW8 - {1'b0, rot_i};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] mix;
    assign mix = opa_i[l*EW +: EW] ^ opb_i[l*EW +: EW];
    // A rotate of EW gives mix>>EW = 0 and mix<<0 = mix, so the value is unchanged.
    assign y_o[l*EW +: EW] = (mix >> rot_i) | (mix << left_amt);
  end

endmodule

// File: rtl/xr_unit.sv
module xr_unit
  import xr_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr_i,
  input  logic [VLEN-1:0] opa_i,
  input  logic [VLEN-1:0] opb_i,
  output logic [VLEN-1:0] res_o,
  output logic [4:0]      dst_idx_o,
  output logic [4:0]      src2_idx_o,
  output logic            match_o,
  output logic            undef_o,
  output logic            wr_en_o
);

  localparam int NSZ = 4;

  if (VLEN % 64 != 0 || VLEN < 64) begin : g_bad_vlen
    initial $fatal(1, "xr_unit: VLEN must be a positive multiple of 64");
  end

  dec_t            dec;
  logic [VLEN-1:0] bank_y [NSZ];
  logic [VLEN-1:0] sel_y;

  // Named events that the checker observes.
  logic       dec_ok;
  logic [6:0] dec_rot;
  logic [7:0] cur_width;

  xr_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  for (genvar k = 0; k < NSZ; k++) begin : g_bank
    xr_lane_bank #(.VLEN(VLEN), .EW(8 << k)) u_bank (
      .opa_i (opa_i),
      .opb_i (opb_i),
      .rot_i (dec.rot),
      .y_o   (bank_y[k])
    );
  end

  assign dec_ok    = dec.hit && !dec.rsvd;
  assign dec_rot   = dec.rot;
  assign cur_width = width_of(dec.esz);
  assign sel_y     = dec_ok ? bank_y[dec.esz] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o      <= '0;
      dst_idx_o  <= '0;
      src2_idx_o <= '0;
      match_o    <= 1'b0;
      undef_o    <= 1'b0;
      wr_en_o    <= 1'b0;
    end else begin
      res_o      <= sel_y;
      dst_idx_o  <= dec.dst;
      src2_idx_o <= dec.src2;
      match_o    <= dec.hit;
      undef_o    <= dec.rsvd;
      wr_en_o    <= dec_ok;
    end
  end

endmodule

// File: rtl/xr_check.sv
module xr_check #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic [9:0]      fld_i,
  input logic            dec_ok,
  input logic [6:0]      dec_rot,
  input logic [7:0]      cur_width,
  input logic [VLEN-1:0] res_o,
  input logic [4:0]      dst_idx_o,
  input logic [4:0]      src2_idx_o,
  input logic            match_o,
  input logic            undef_o,
  input logic            wr_en_o
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (match_o && !undef_o));

  p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> (res_o == '0));

  p_rsvd_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> match_o);

  p_dst_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |-> (dst_idx_o == $past(fld_i[4:0])));

  p_src2_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |-> (src2_idx_o == $past(fld_i[9:5])));

  p_rot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ok |-> ((dec_rot != 7'd0) && ({1'b0, dec_rot} <= cur_width)));

  p_wr_follows_ok_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |-> (wr_en_o == $past(dec_ok)));

endmodule

bind xr_unit xr_check #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fld_i      (instr_i[9:0]),
  .dec_ok     (dec_ok),
  .dec_rot    (dec_rot),
  .cur_width  (cur_width),
  .res_o      (res_o),
  .dst_idx_o  (dst_idx_o),
  .src2_idx_o (src2_idx_o),
  .match_o    (match_o),
  .undef_o    (undef_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/sim_xr_unit.sv
`timescale 1ns/1ps
module sim_xr_unit;

  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [VLEN-1:0] opa_i = '0;
  logic [VLEN-1:0] opb_i = '0;
  logic [VLEN-1:0] res_o;
  logic [4:0]      dst_idx_o, src2_idx_o;
  logic            match_o, undef_o, wr_en_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xr_unit #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .opa_i(opa_i), .opb_i(opb_i),
    .res_o(res_o), .dst_idx_o(dst_idx_o), .src2_idx_o(src2_idx_o),
    .match_o(match_o), .undef_o(undef_o), .wr_en_o(wr_en_o)
  );

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Build a word from a width (8..64) and a rotate amount (1..width).
  function automatic logic [31:0] mk(input int w, input int rot,
                                     input logic [4:0] zm, input logic [4:0] zdn);
    logic [6:0] imm7;
    imm7 = 7'(2 * w - rot);
    return {8'h04, imm7[6:5], 1'b1, imm7[4:3], imm7[2:0], 6'b001101, zm, zdn};
  endfunction

  // Bit-index model: out bit i takes in bit (i + rot) mod w, lane by lane.
  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a,
                                            input logic [VLEN-1:0] b,
                                            input int w, input int rot);
    logic [VLEN-1:0] x, r;
    x = a ^ b;
    r = '0;
    for (int e = 0; e < VLEN / w; e++)
      for (int i = 0; i < w; i++)
        r[e*w + i] = x[e*w + ((i + rot) % w)];
    return r;
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [VLEN-1:0] a,
                       input logic [VLEN-1:0] b);
    @(negedge clk);
    instr_i = ins; opa_i = a; opb_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run_op(input int w, input int rot, input logic [VLEN-1:0] a,
                        input logic [VLEN-1:0] b, input string req);
    logic [VLEN-1:0] exp;
    exp = model(a, b, w, rot);
    apply(mk(w, rot, 5'd9, 5'd22), a, b);
    chk(res_o == exp, req, res_o, exp);
    chk(wr_en_o && match_o && !undef_o, {req, " R8 flags"},
        {match_o, undef_o, wr_en_o}, 3'b101);
  endtask

  task automatic t_reset;
    apply(mk(8, 3, 5'd1, 5'd2), {4{32'hDEADBEEF}}, '0);
    chk(res_o == '0 && !wr_en_o && !match_o && !undef_o && dst_idx_o == 0 && src2_idx_o == 0,
        "R9 reset", res_o, '0);
  endtask

  task automatic t_widths;
    logic [VLEN-1:0] a, b;
    a = {32'h0123_4567, 32'h89AB_CDEF, 32'hF0E1_D2C3, 32'hB4A5_9687};
    b = {32'h5A5A_0F0F, 32'h3C3C_9999, 32'h1248_8421, 32'h7777_0001};
    run_op(8, 3, a, b, "R6 R4 byte lanes");
    run_op(16, 5, a, b, "R6 R4 half lanes");
    run_op(32, 17, a, b, "R6 R4 word lanes");
    run_op(64, 40, a, b, "R6 R4 dword lanes");
    run_op(64, 1, a, ~b, "R5 rotate of one");
    run_op(16, 16, a, b, "R7 full rotate half");
    run_op(8, 8, a, ~a, "R7 full rotate byte ones");
    run_op(64, 64, a, b, "R7 full rotate dword");
    run_op(32, 32, b, a, "R7 full rotate word");
    // Single set bit in lane 0 only: checks lane placement.
    run_op(8, 1, 128'h1, '0, "R6 lane0 lsb placement");
  endtask

  task automatic t_sweep;
    logic [VLEN-1:0] a, b;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = 8 << k;
      for (int r = 1; r <= w; r += (w / 4)) begin
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        run_op(w, r, a, b, "R5 sweep");
      end
    end
  endtask

  task automatic t_reject;
    logic [31:0] good, bad;
    logic [VLEN-1:0] a;
    a = {4{32'hCAFE_F00D}};
    good = mk(32, 7, 5'd17, 5'd30);
    bad = good ^ 32'h8000_0000;
    apply(bad, a, ~a);
    chk(!match_o && !wr_en_o && res_o == '0, "R1 R8 opcode hi broken", res_o, '0);
    chk(dst_idx_o == 5'd30 && src2_idx_o == 5'd17, "R2 fields on non-match",
        {dst_idx_o, src2_idx_o}, {5'd30, 5'd17});
    bad = good & ~32'h0020_0000;
    apply(bad, a, ~a);
    chk(!match_o && res_o == '0, "R1 bit21 clear", res_o, '0);
    bad = good ^ 32'h0000_0400;
    apply(bad, a, ~a);
    chk(!match_o && res_o == '0, "R1 mid field broken", res_o, '0);
    apply(good, a, ~a);
    chk(match_o && wr_en_o, "R1 good word matches", match_o, 1'b1);
  endtask

  task automatic t_reserved;
    logic [VLEN-1:0] a;
    a = {4{32'h1357_9BDF}};
    for (int i3 = 0; i3 < 8; i3 += 7) begin
      apply({8'h04, 2'b00, 1'b1, 2'b00, 3'(i3), 6'b001101, 5'd4, 5'd5}, a, '0);
      chk(match_o && undef_o && !wr_en_o && res_o == '0, "R3 R8 reserved size",
          {match_o, undef_o, wr_en_o}, 3'b110);
    end
    // Reserved-size bits on a non-matching word must not raise undef.
    apply({8'h05, 2'b00, 1'b1, 2'b00, 3'd0, 6'b001101, 5'd4, 5'd5}, a, '0);
    chk(!undef_o && !match_o, "R3 undef needs match", undef_o, 1'b0);
  endtask

  task automatic t_fields;
    for (int i = 0; i < 32; i += 11) begin
      apply(mk(16, 2, 5'(31 - i), 5'(i)), '1, '0);
      chk(dst_idx_o == 5'(i) && src2_idx_o == 5'(31 - i), "R2 index fields",
          {dst_idx_o, src2_idx_o}, {5'(i), 5'(31 - i)});
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    instr_i = mk(8, 4, 5'd3, 5'd6); opa_i = '1; opb_i = '0;
    @(posedge clk);
    #0.5;
    instr_i = 32'h0;
    #0.5;
    chk(wr_en_o && res_o == '1, "R9 one cycle latency hold", res_o, '1);
    @(posedge clk);
    #1;
    chk(!wr_en_o && res_o == '0, "R9 next cycle follows input", res_o, '0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_widths();
    t_sweep();
    t_reject();
    t_reserved();
    t_fields();
    t_latency();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(res_o == '0 && !match_o && !wr_en_o, "R9 reset mid-run", res_o, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule